// File: doc/BRIEF.md
# Reed-Solomon Parity Encoder (16 check symbols, GF(2^8))

This block adds sixteen check bytes to a message to form a systematic Reed-Solomon codeword over GF(2^8). Message bytes arrive one per cycle under a valid flag, with flags that mark the opening and closing byte. Each accepted byte is forwarded to the output in the same cycle. It is also folded into a sixteen-stage remainder register.

The remainder register is fed at its most significant end. The incoming byte is XORed with the top stage to form the feedback. The feedback is then scaled by the fixed generator coefficients and added into every stage. Because of this, no shift-in prefill is needed. The remainder is complete on the clock edge that absorbs the closing byte.

For the next sixteen cycles the block emits the check bytes, highest degree first, and holds `in_ready` low. A new message may start in the cycle after the final check byte.

Top module: `rs_parity_enc`

## Requirements
- R1: An accepted message byte (in_valid and in_ready both high) appears on out_data in the same cycle, with out_valid=1 and out_is_parity=0.
- R2: After the closing byte is accepted, the next 16 cycles carry out_valid=1 and out_is_parity=1. The check bytes come out as the remainder coefficients of x^15 first, down to x^0 last.
- R3: The check bytes equal m(x)*x^16 mod g(x). Here the first message byte is the highest-degree coefficient of m(x). The field uses primitive polynomial 0x11D with alpha=0x02, and g(x) is the product of (x + alpha^i) for i=0..15.
- R4: out_last is high only together with the sixteenth check byte.
- R5: During check-byte output in_ready is 0, and in_valid, in_first, in_last and in_data have no effect on the emitted bytes.
- R6: A byte accepted with in_first=1 discards any earlier partial remainder. A new message may begin in the cycle right after out_last.
- R7: A one-byte message (in_first and in_last high together) yields its correct check bytes.
- R8: After reset, in_ready=1, and out_valid=0 while in_valid=0.
- R9: The encoding is linear. The check bytes of the XOR of two equal-length messages equal the XOR of their check bytes.
- R10: Messages of up to 239 bytes (a 255-byte codeword) are encoded correctly.
- R11: Cycles with in_valid=0 inside a message leave the remainder unchanged and produce out_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Message byte present |
| in_first | input | 1 | Byte is the opening byte of a message |
| in_last | input | 1 | Byte is the closing byte of a message |
| in_data | input | 8 | Message byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | out_data carries a codeword byte |
| out_data | output | 8 | Codeword byte (message or check) |
| out_is_parity | output | 1 | out_data is a check byte |
| out_last | output | 1 | Final byte of the codeword |

## Verification
The encoder is exercised with several kinds of message:
- A one-byte message tests the case where the first byte's feedback is taken with the top stage forced to zero.
- A short patterned message, and a full 239-byte message, test feedback accumulated over many cycles.
- Messages with idle gaps show whether the register moves when it should hold.
- A message started and abandoned, followed by a fresh one, shows whether the opening flag truly clears the old state.
- Valid held high through check-byte output shows whether held-off input leaks into the remainder.
- Three messages related by XOR test linearity independently of the reference division.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 8;
  localparam int NPAR  = 16;
  localparam logic [SYM_W-1:0] PRIM_LOW = 8'h1D;  // x^8+x^4+x^3+x^2+1 without x^8

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a_in,
                                              input logic [SYM_W-1:0] b_in);
    logic [SYM_W-1:0] acc;
    logic [SYM_W-1:0] a;
    acc = '0;
    a   = a_in;
    for (int i = 0; i < SYM_W; i++) begin
      if (b_in[i]) acc = acc ^ a;
      a = a[SYM_W-1] ? ((a << 1) ^ PRIM_LOW) : (a << 1);
    end
    return acc;
  endfunction

  // Lower NPAR coefficients of prod (x + alpha^i), i = 0..NPAR-1; byte j = coef of x^j
  function automatic logic [NPAR*SYM_W-1:0] gen_coefs();
    logic [SYM_W-1:0] g [NPAR+1];
    logic [SYM_W-1:0] root;
    logic [NPAR*SYM_W-1:0] res;
    for (int j = 0; j <= NPAR; j++) g[j] = '0;
    g[0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < NPAR; i++) begin
      for (int j = NPAR; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, 8'h02);
    end
    res = '0;
    for (int j = 0; j < NPAR; j++) res[j*SYM_W +: SYM_W] = g[j];
    return res;
  endfunction

  localparam logic [NPAR*SYM_W-1:0] GEN = gen_coefs();
endpackage

// File: rtl/gf_const_mul.sv
module gf_const_mul
  import rs_enc_pkg::*;
#(
  parameter logic [SYM_W-1:0] COEF = 8'h01
) (
  input  logic [SYM_W-1:0] din,
  output logic [SYM_W-1:0] dout
);
  always_comb begin
    dout = gf_mul(din, COEF);
  end
endmodule

// File: rtl/rs_rem_reg.sv
module rs_rem_reg
  import rs_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,      // absorb a message symbol
  input  logic             first,     // symbol opens a message: discard old state
  input  logic             shift,     // move check symbols toward the top
  input  logic [SYM_W-1:0] sym,
  output logic [SYM_W-1:0] top
);
  logic [SYM_W-1:0] rem_q [NPAR];
  logic [SYM_W-1:0] rem_d [NPAR];
  logic [SYM_W-1:0] prod  [NPAR];
  logic [SYM_W-1:0] fb;

  assign fb = sym ^ (first ? '0 : rem_q[NPAR-1]);

  for (genvar gi = 0; gi < NPAR; gi++) begin : g_mul
    gf_const_mul #(.COEF(GEN[gi*SYM_W +: SYM_W])) mul_i (
      .din  (fb),
      .dout (prod[gi])
    );
  end

  always_comb begin
    for (int i = 0; i < NPAR; i++) begin
      rem_d[i] = rem_q[i];
      if (load) begin
        rem_d[i] = ((i == 0 || first) ? '0 : rem_q[(i == 0) ? 0 : i-1]) ^ prod[i];
      end else if (shift) begin
        rem_d[i] = (i == 0) ? '0 : rem_q[(i == 0) ? 0 : i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAR; i++) rem_q[i] <= '0;
    end else if (load || shift) begin
      for (int i = 0; i < NPAR; i++) rem_q[i] <= rem_d[i];
    end
  end

  assign top = rem_q[NPAR-1];

  // R2: output shifting brings the next lower coefficient to the top
  assert_shift_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (top == $past(rem_q[NPAR-2])));

  // R11: no load and no shift keeps the register still
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(top));
endmodule

// File: rtl/rs_out_seq.sv
module rs_out_seq
  import rs_enc_pkg::*;
#(
  parameter int MAX_MSG = 239
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic first,
  input  logic last,
  output logic par_active,
  output logic par_final
);
  localparam int CNT_W = $clog2(NPAR);
  localparam int LEN_W = $clog2(MAX_MSG + 1);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    len_d = len_q;
    if (act_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(NPAR-1)) act_d = 1'b0;
    end else if (accept) begin
      len_d = first ? LEN_W'(1) : len_q + 1'b1;
      if (last) begin
        act_d = 1'b1;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign par_active = act_q;
  assign par_final  = act_q && (cnt_q == CNT_W'(NPAR-1));

  // R10: a message never grows past the configured limit
  assert_msg_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !first) |-> (len_q < LEN_W'(MAX_MSG)));

  // R2: check-byte phase starts right after the closing byte
  assert_parity_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last) |=> par_active);

  // R2: check-byte phase runs without a break until its final byte
  assert_parity_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (par_active && !par_final) |=> par_active);
endmodule

// File: rtl/rs_parity_enc.sv
module rs_parity_enc
  import rs_enc_pkg::*;
#(
  parameter int MAX_MSG = 239
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  input  logic [SYM_W-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             out_is_parity,
  output logic             out_last
);
  logic             rst_meta_q, rst_sync_q;
  logic             accept;
  logic             par_active;
  logic             par_final;
  logic [SYM_W-1:0] top;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign in_ready = !par_active;
  assign accept   = in_valid && in_ready;

  rs_out_seq #(.MAX_MSG(MAX_MSG)) seq_i (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .accept     (accept),
    .first      (in_first),
    .last       (in_last),
    .par_active (par_active),
    .par_final  (par_final)
  );

  rs_rem_reg rem_i (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .load  (accept),
    .first (in_first),
    .shift (par_active),
    .sym   (in_data),
    .top   (top)
  );

  always_comb begin
    out_valid     = par_active || accept;
    out_data      = par_active ? top : in_data;
    out_is_parity = par_active;
    out_last      = par_final;
  end

  // R4: last marker closes the codeword and the check phase ends
  assert_last_ends_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    out_last |=> !out_is_parity);

  // R5: input is held off whenever check bytes are on the output
  assert_holdoff_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    out_is_parity |-> (!in_ready && out_valid));

  // R1: an accepted byte is passed through unchanged
  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (in_valid && in_ready) |-> (out_valid && out_data == in_data && !out_is_parity));
endmodule

// File: tb/rs_parity_enc_tb_top.sv
module rs_parity_enc_tb_top;
  localparam int NP = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid, out_is_parity, out_last;
  logic [7:0] out_data;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] msg  [0:255];
  logic [7:0] expp [0:NP-1];
  logic [7:0] gotp [0:NP-1];
  logic [7:0] bg   [0:NP];

  always #2 clk = ~clk;  // 250 MHz

  rs_parity_enc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data),
    .out_is_parity(out_is_parity), .out_last(out_last)
  );

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011D << (i - 8));
    return p[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
    end
  endtask

  task automatic build_gen();
    logic [7:0] r = 8'h01;
    for (int j = 0; j <= NP; j++) bg[j] = 8'h00;
    bg[0] = 8'h01;
    for (int i = 0; i < NP; i++) begin
      for (int j = NP; j >= 1; j--) bg[j] = bg[j-1] ^ fmul(bg[j], r);
      bg[0] = fmul(bg[0], r);
      r = fmul(r, 8'h02);
    end
  endtask

  // polynomial long division of m(x)*x^16 by g(x), expp[0] = coef of x^15
  task automatic ref_div(input int len);
    logic [7:0] w [0:255+NP];
    for (int i = 0; i < len + NP; i++) w[i] = (i < len) ? msg[i] : 8'h00;
    for (int i = 0; i < len; i++) begin
      logic [7:0] q = w[i];
      for (int j = 0; j <= NP; j++) w[i+j] = w[i+j] ^ fmul(q, bg[NP-j]);
    end
    for (int k = 0; k < NP; k++) expp[k] = w[len+k];
  endtask

  task automatic fill(input int len, input int seed);
    for (int i = 0; i < len; i++) msg[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 3));
  endtask

  // drives a message, checks pass-through and check bytes
  task automatic run_cw(input string req, input int len, input bit gaps, input bit hold_in);
    ref_div(len);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0; in_data = 8'hFF; in_first = 1'b1; in_last = 1'b1;
        #1 chk(!out_valid, "R11 idle out_valid", out_valid, 0);
        @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = msg[i]; in_first = (i == 0); in_last = (i == len - 1);
      #1;
      chk(in_ready && out_valid && !out_is_parity, "R1 accept flags",
          {in_ready, out_valid, out_is_parity}, 3'b110);
      chk(out_data == msg[i], "R1 pass-through", out_data, msg[i]);
      @(posedge clk);
    end
    for (int k = 0; k < NP; k++) begin
      @(negedge clk);
      in_valid = hold_in; in_data = 8'(k * 91 + 7); in_first = hold_in; in_last = hold_in;
      #1;
      chk(out_valid && out_is_parity && !in_ready, "R2/R5 parity phase flags",
          {out_valid, out_is_parity, in_ready}, 3'b110);
      chk(out_last == (k == NP - 1), "R4 out_last", out_last, (k == NP - 1));
      gotp[k] = out_data;
      chk(out_data == expp[k], req, out_data, expp[k]);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic t_reset();
    #1 chk(in_ready == 1'b1, "R8 reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
  endtask

  task automatic t_single();
    msg[0] = 8'h5A;
    run_cw("R7 single-byte parity", 1, 1'b0, 1'b0);
  endtask

  task automatic t_short();
    fill(20, 1);
    run_cw("R3 short message parity", 20, 1'b0, 1'b0);
  endtask

  task automatic t_max();
    fill(239, 4);
    run_cw("R10 239-byte parity", 239, 1'b0, 1'b0);
  endtask

  task automatic t_gaps();
    fill(30, 7);
    run_cw("R11 gapped message parity", 30, 1'b1, 1'b0);
  endtask

  task automatic t_holdoff();
    fill(12, 9);
    run_cw("R5 held-off input ignored", 12, 1'b0, 1'b1);
  endtask

  task automatic t_restart();
    // abandoned partial message, then a fresh one
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(i * 13 + 200); in_first = (i == 0); in_last = 1'b0;
      @(posedge clk);
    end
    fill(9, 12);
    run_cw("R6 first clears old state", 9, 1'b0, 1'b0);
    // back-to-back: next message's first byte right after out_last
    fill(15, 13);
    ref_div(15);
    for (int i = 0; i < 15; i++) begin
      if (i == 0) #0; else @(negedge clk);
      in_valid = 1'b1; in_data = msg[i]; in_first = (i == 0); in_last = (i == 14);
      #1 chk(in_ready == 1'b1, "R6 back-to-back accept", in_ready, 1);
      @(posedge clk);
    end
    for (int k = 0; k < NP; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
      #1 chk(out_data == expp[k], "R6 back-to-back parity", out_data, expp[k]);
      @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_linear();
    logic [7:0] ma [0:31];
    logic [7:0] pa [0:NP-1];
    logic [7:0] pb [0:NP-1];
    fill(32, 21);
    for (int i = 0; i < 32; i++) ma[i] = msg[i];
    run_cw("R9 linear A", 32, 1'b0, 1'b0);
    for (int k = 0; k < NP; k++) pa[k] = gotp[k];
    fill(32, 33);
    run_cw("R9 linear B", 32, 1'b0, 1'b0);
    for (int k = 0; k < NP; k++) pb[k] = gotp[k];
    for (int i = 0; i < 32; i++) msg[i] = msg[i] ^ ma[i];
    run_cw("R9 linear A^B", 32, 1'b0, 1'b0);
    for (int k = 0; k < NP; k++)
      chk(gotp[k] == (pa[k] ^ pb[k]), "R9 XOR of parities", gotp[k], pa[k] ^ pb[k]);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    build_gen();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_single();
    t_short();
    t_max();
    t_gaps();
    t_holdoff();
    t_restart();
    t_linear();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule